// File: doc/BRIEF.md
# Vector String Range Compare Unit

This unit scans a 128-bit data vector and sorts each element into match or no-match, using a set of range tests. A second 128-bit operand holds the bounds as adjacent pairs of elements. A third 128-bit operand supplies one acceptance byte per bound. That byte says whether data equal to, below or above the bound passes. An element matches when both bounds of at least one pair accept it. The element width is 8, 16 or 32 bits. Element 0 is the most significant element, and byte offsets count from the most significant byte.

A 4-bit mode field controls four options: inverting the per-element outcome, the output format, a search for an all-zero terminator element, and a request for a 2-bit condition code. The output is either a mask, with every matching element set to all ones, or a byte index. The byte index is the nearer of the first match and the first zero, placed in the upper doubleword, and the value 16 means nothing was found. An unsupported element-size code raises a specification flag and leaves the result and the condition code unchanged.

A small controller has two states. IDLE waits for `start`. The transition IDLE→REPORT fires on `start` and loads the output registers. REPORT drives `done` for one cycle. REPORT→REPORT fires on a back-to-back `start`, and REPORT→IDLE fires when `start` is low.

Top module: `vrange_scan`

## Requirements
- R1: `elem_size` 0, 1 and 2 select 8-, 16- and 32-bit elements. Code 3 sets `spec_err` and clears `cc_valid`, and leaves `result` and `cc` unchanged. Any legal code clears `spec_err`.
- R2: Pair k uses elements 2k (first bound) and 2k+1 (second bound) of `bound_vec`. The acceptance byte of bound j is the most significant byte of element j of `ctl_vec`, and the other bytes of that element are ignored. Element 0 occupies the most significant bits.
- R3: In an acceptance byte, bit 7 passes data equal to the bound, bit 6 passes data below it and bit 5 passes data above it. All comparisons are unsigned.
- R4: A pair matches only when both of its bounds pass. An element matches when any pair matches.
- R5: `mode[3]` = 1 inverts every element's match outcome.
- R6: When `mode[2]` = 1 (mask format), every matching element is written as all ones and every other element as zero, including elements after a zero terminator.
- R7: When `mode[2]` = 0 (index format), `result[127:64]` holds min(first-match byte, first-zero byte) and `result[63:0]` is zero. The value 16 means none. Elements at or after the first zero element are not evaluated.
- R8: When `mode[1]` = 1, the first-zero byte is the byte offset of the lowest-numbered all-zero data element. When `mode[1]` = 0, the first-zero byte is 16.
- R9: The condition code is 3 when there is no match and no zero, 1 when there is a match but no zero, 2 when the first match lies before the first zero, and 0 otherwise.
- R10: When `mode[0]` = 1, a legal operation updates `cc` and sets `cc_valid`. When `mode[0]` = 0, `cc` holds and `cc_valid` is 0.
- R11: All outputs are registered at the clock edge that samples `start`, and `done` is high for the following cycle only. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation with the operands present this cycle |
| data_vec | input | 128 | Data vector to classify |
| bound_vec | input | 128 | Range bounds, in pairs of elements |
| ctl_vec | input | 128 | Acceptance bytes, in the top byte of each element |
| elem_size | input | 2 | Element size code |
| mode | input | 4 | {invert, mask format, zero search, want cc} |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Mask or byte-index result |
| cc | output | 2 | Condition code |
| cc_valid | output | 1 | Last operation produced a condition code |
| spec_err | output | 1 | Last operation had an illegal element size |

## Verification
Four properties are checked on every cycle:
- `done` follows a `start`.
- An illegal size freezes the result and raises the flag.
- An index-format result never exceeds 16 and always has a zero lower doubleword.
- A code that was not requested stays put, and with zero search off the code is odd.

Whether a given element truly matches depends on the bounds and the acceptance bytes, and only the bench scenarios can show this. That covers which pair or bound gates the match, equality and unsigned ordering, inversion, the early stop at a zero, and the full four-way code.

// File: rtl/vrange_pkg.sv
package vrange_pkg;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_BAD = 2'd3
    } esz_e;

    typedef struct packed {
        logic invert;
        logic mask_fmt;
        logic zero_srch;
        logic want_cc;
    } mode_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ctrl_st_e;

    // one bound test: acceptance byte bit7 = equal, bit6 = below, bit5 = above
    function automatic logic bound_accept(input logic [31:0] d,
                                          input logic [31:0] bnd,
                                          input logic [7:0]  acc);
        logic ok;
        if (d < bnd)      ok = acc[6];
        else if (d > bnd) ok = acc[5];
        else              ok = acc[7];
        return ok;
    endfunction

endpackage

// File: rtl/vrange_lane_match.sv
module vrange_lane_match
    import vrange_pkg::*;
#(
    parameter int EW = 8,
    parameter int VW = 128,
    localparam int NE = VW / EW,
    localparam int NP = NE / 2
) (
    input  logic [VW-1:0]   data_v,
    input  logic [VW-1:0]   bound_v,
    input  logic [NE*8-1:0] acc_b,
    output logic [NE-1:0]   hit_raw,
    output logic [NE-1:0]   is_zero
);

    genvar i, k;
    generate
        for (i = 0; i < NE; i++) begin : g_elem
            logic [EW-1:0] d;
            logic [NP-1:0] pair_ok;
            assign d          = data_v[VW-1-i*EW -: EW];
            assign is_zero[i] = (d == '0);
            for (k = 0; k < NP; k++) begin : g_pair
                logic [EW-1:0] lo_b;
                logic [EW-1:0] hi_b;
                logic [7:0]    lo_a;
                logic [7:0]    hi_a;
                assign lo_b = bound_v[VW-1-(2*k)*EW -: EW];
                assign hi_b = bound_v[VW-1-(2*k+1)*EW -: EW];
                assign lo_a = acc_b[NE*8-1-(2*k)*8 -: 8];
                assign hi_a = acc_b[NE*8-1-(2*k+1)*8 -: 8];
                assign pair_ok[k] = bound_accept(32'(d), 32'(lo_b), lo_a)
                                  && bound_accept(32'(d), 32'(hi_b), hi_a);
            end
            assign hit_raw[i] = |pair_ok;
        end
    endgenerate

endmodule

// File: rtl/vrange_first_idx.sv
module vrange_first_idx #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vrange_ctrl.sv
module vrange_ctrl
    import vrange_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic done
);

    ctrl_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_REPORT;
            ST_REPORT: state_nx = start ? ST_REPORT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        load = start;
        unique case (state)
            ST_IDLE:   done = 1'b0;
            ST_REPORT: done = 1'b1;
        endcase
    end

    // R11
    r11_done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

endmodule

// File: rtl/vrange_scan.sv
module vrange_scan
    import vrange_pkg::*;
#(
    parameter int VW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] data_vec,
    input  logic [VW-1:0] bound_vec,
    input  logic [VW-1:0] ctl_vec,
    input  logic [1:0]    elem_size,
    input  logic [3:0]    mode,
    output logic          done,
    output logic [VW-1:0] result,
    output logic [1:0]    cc,
    output logic          cc_valid,
    output logic          spec_err
);

    localparam int NB    = VW / 8;
    localparam int IW    = $clog2(NB);
    localparam int BW    = IW + 1;
    localparam int NSIZE = 3;
    localparam int DW    = VW / 2;

    logic          load;
    mode_t         md;
    logic          bad_sz;
    logic [1:0]    es_c;
    logic [NB-1:0] raw_s  [NSIZE];
    logic [NB-1:0] zero_s [NSIZE];

    assign md     = mode_t'(mode);
    assign bad_sz = (esz_e'(elem_size) == ESZ_BAD);
    assign es_c   = bad_sz ? 2'd0 : elem_size;

    vrange_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .done  (done)
    );

    genvar g, j;
    generate
        for (g = 0; g < NSIZE; g++) begin : g_size
            localparam int EW = 8 << g;
            localparam int NE = VW / EW;
            logic [NE*8-1:0] acc_b;
            logic [NE-1:0]   hit_w;
            logic [NE-1:0]   zer_w;
            for (j = 0; j < NE; j++) begin : g_acc
                assign acc_b[NE*8-1-j*8 -: 8] = ctl_vec[VW-1-j*EW -: 8];
            end
            vrange_lane_match #(.EW(EW), .VW(VW)) u_lane (
                .data_v  (data_vec),
                .bound_v (bound_vec),
                .acc_b   (acc_b),
                .hit_raw (hit_w),
                .is_zero (zer_w)
            );
            assign raw_s[g]  = NB'(hit_w);
            assign zero_s[g] = NB'(zer_w);
        end
    endgenerate

    logic [NB-1:0] valid_e, hit_all, zvec, before_z, hit_eval;
    logic          zf, mf;
    logic [IW-1:0] zi, mi;
    logic [BW-1:0] fz_byte, fm_byte, idx_min;
    logic [1:0]    cc_nx;
    logic [VW-1:0] res_nx;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            valid_e[i] = (i < (NB >> es_c));
        end
        hit_all = (raw_s[es_c] ^ {NB{md.invert}}) & valid_e;
        zvec    = zero_s[es_c] & valid_e & {NB{md.zero_srch}};
    end

    vrange_first_idx #(.N(NB)) u_fz (.vec(zvec), .found(zf), .idx(zi));

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            before_z[i] = !zf || (IW'(i) < zi);
        end
        hit_eval = md.mask_fmt ? hit_all : (hit_all & before_z);
    end

    vrange_first_idx #(.N(NB)) u_fm (.vec(hit_eval), .found(mf), .idx(mi));

    always_comb begin
        fz_byte = zf ? (BW'(zi) << es_c) : BW'(NB);
        fm_byte = mf ? (BW'(mi) << es_c) : BW'(NB);
        idx_min = (fm_byte < fz_byte) ? fm_byte : fz_byte;
        if (!zf && !mf)             cc_nx = 2'd3;
        else if (!zf)               cc_nx = 2'd1;
        else if (fm_byte < fz_byte) cc_nx = 2'd2;
        else                        cc_nx = 2'd0;
        res_nx = '0;
        if (md.mask_fmt) begin
            for (int b = 0; b < NB; b++) begin
                res_nx[VW-1-8*b -: 8] = {8{hit_all[IW'(b) >> es_c]}};
            end
        end else begin
            res_nx[VW-1 -: DW] = DW'(idx_min);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            cc       <= '0;
            cc_valid <= 1'b0;
            spec_err <= 1'b0;
        end else if (load) begin
            spec_err <= bad_sz;
            cc_valid <= !bad_sz && md.want_cc;
            if (!bad_sz) result <= res_nx;
            if (!bad_sz && md.want_cc) cc <= cc_nx;
        end
    end

    // R1
    r1_bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && elem_size == 2'd3) |=> (spec_err && !cc_valid && $stable(result)));

    // R7
    r7_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && elem_size != 2'd3 && !mode[2]) |=>
        (result[DW-1:0] == '0 && result[VW-1:DW] <= DW'(NB)));

    // R10
    r10_cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode[0]) |=> (!cc_valid && $stable(cc)));

    // R9
    r9_nozero_odd_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && elem_size != 2'd3 && mode[0] && !mode[1]) |=> (cc_valid && cc[0]));

endmodule

// File: tb/vrange_scan_tb.sv
module vrange_scan_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [127:0] data_vec, bound_vec, ctl_vec;
    logic [1:0]   elem_size;
    logic [3:0]   mode;
    logic         done;
    logic [127:0] result;
    logic [1:0]   cc;
    logic         cc_valid;
    logic         spec_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [127:0] exp_res = '0;
    logic [1:0]   exp_cc  = '0;

    always #4 clk = ~clk;

    vrange_scan u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .data_vec(data_vec), .bound_vec(bound_vec), .ctl_vec(ctl_vec),
        .elem_size(elem_size), .mode(mode), .done(done), .result(result),
        .cc(cc), .cc_valid(cc_valid), .spec_err(spec_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] elem_of(input logic [127:0] v, input int i, input int es);
        int w = 8 << es;
        logic [127:0] t = v >> (128 - (i + 1) * w);
        return 32'(t) & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1));
    endfunction

    function automatic bit passes(input logic [31:0] d, input logic [31:0] bnd, input logic [7:0] a);
        if (d == bnd) return a[7];
        if (d < bnd)  return a[6];
        return a[5];
    endfunction

    task automatic ref_model(input int es, input logic [3:0] md, input logic [127:0] a,
                             input logic [127:0] b, input logic [127:0] c,
                             output logic [127:0] r, output logic [1:0] ccx);
        int sz = 1 << es;
        int n = 16 / sz;
        int fz = 16;
        int fm = 16;
        r = '0;
        if (md[1]) begin
            for (int i = n - 1; i >= 0; i--) if (elem_of(a, i, es) == 0) fz = i * sz;
        end
        for (int i = 0; i < n; i++) begin
            bit any = 0;
            if (!md[2] && i * sz == fz) break;
            for (int p = 0; p < n; p += 2) begin
                if (passes(elem_of(a, i, es), elem_of(b, p, es), c[127-8*(p*sz) -: 8]) &&
                    passes(elem_of(a, i, es), elem_of(b, p+1, es), c[127-8*((p+1)*sz) -: 8]))
                    any = 1;
            end
            any = any ^ md[3];
            if (any) begin
                if (md[2]) begin
                    if (fm == 16) fm = i * sz;
                    for (int q = i * sz; q < (i + 1) * sz; q++) r[127-8*q -: 8] = 8'hFF;
                end else begin
                    fm = i * sz;
                    break;
                end
            end
        end
        if (!md[2]) r = {64'(fm < fz ? fm : fz), 64'd0};
        if (fz == 16 && fm == 16) ccx = 2'd3;
        else if (fz == 16)        ccx = 2'd1;
        else if (fm < fz)         ccx = 2'd2;
        else                      ccx = 2'd0;
    endtask

    task automatic run_op(input int es, input logic [3:0] md, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] c);
        @(negedge clk);
        elem_size = 2'(es); mode = md; data_vec = a; bound_vec = b; ctl_vec = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [127:0] rvec(input int es, input bit allow_zero);
        logic [127:0] v = '0;
        int w = 8 << es;
        for (int i = 0; i < 16 / (1 << es); i++) begin
            int r = $urandom_range(0, 9);
            logic [31:0] x = (r == 0) ? (allow_zero ? 32'd0 : 32'd1) : (r < 7 ? 32'(r) : $urandom);
            if (w < 32) x = x & ((32'd1 << w) - 1);
            v = v | (128'(x) << (128 - (i + 1) * w));
        end
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] da, dz, d5, bd, ct, r;
        logic [1:0] ccx;
        rst_n = 1'b0; start = 1'b0; data_vec = '0; bound_vec = '0; ctl_vec = '0;
        elem_size = '0; mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {result, 2'b0, cc, done, cc_valid, spec_err},
            {128'd0, 7'd0});
        rst_n = 1'b1;

        da = {16{8'h10}}; da[103 -: 8] = 8'h20;
        dz = da; dz[111 -: 8] = 8'h00;
        d5 = da; d5[87 -: 8] = 8'h00;
        bd = '0; bd[127 -: 8] = 8'h18; bd[119 -: 8] = 8'h28;
        ct = '0; ct[127 -: 8] = 8'h20; ct[119 -: 8] = 8'h40;

        run_op(0, 4'b0000, da, bd, ct);
        chk("R11 done pulse", 128'(done), 128'd1);
        chk("R4 pair match index", result, {64'd3, 64'd0});
        @(negedge clk);
        chk("R11 done single cycle", 128'(done), 128'd0);

        run_op(0, 4'b1000, da, bd, ct);
        chk("R5 inverted first hit", result, {64'd0, 64'd0});

        run_op(0, 4'b0011, dz, bd, ct);
        chk("R7 stop at zero", result, {64'd2, 64'd0});
        chk("R9 cc zero first", 128'({cc_valid, cc}), 128'({1'b1, 2'd0}));

        run_op(0, 4'b0111, dz, bd, ct);
        chk("R6 mask past zero", result, 128'h000000FF << 96);
        chk("R9 cc match after zero", 128'({cc_valid, cc}), 128'({1'b1, 2'd0}));

        run_op(0, 4'b0001, dz, bd, ct);
        chk("R8 zero search off", result, {64'd3, 64'd0});
        chk("R9 cc match no zero", 128'(cc), 128'd1);

        run_op(0, 4'b0011, {16{8'h10}}, bd, ct);
        chk("R7 none found", result, {64'd16, 64'd0});
        chk("R9 cc none", 128'(cc), 128'd3);

        run_op(0, 4'b0011, d5, bd, ct);
        chk("R9 cc match before zero", 128'(cc), 128'd2);
        chk("R8 match before zero idx", result, {64'd3, 64'd0});

        run_op(0, 4'b0000, da, bd, ct);
        chk("R10 cc held", 128'({cc_valid, cc}), 128'({1'b0, 2'd2}));

        run_op(3, 4'b0111, {16{8'h55}}, bd, ct);
        chk("R1 spec flag", 128'({spec_err, cc_valid, cc}), 128'({1'b1, 1'b0, 2'd2}));
        chk("R1 result unchanged", result, {64'd3, 64'd0});

        begin
            logic [127:0] b3, c3;
            b3 = bd; b3[127 -: 8] = 8'h20; b3[119 -: 8] = 8'h20;
            c3 = ct; c3[127 -: 8] = 8'h80; c3[119 -: 8] = 8'h80;
            run_op(0, 4'b0000, da, b3, c3);
            chk("R3 equality accept", result, {64'd3, 64'd0});
            c3 = ct; c3[119 -: 8] = 8'h00;
            run_op(0, 4'b0000, da, bd, c3);
            chk("R4 one bound fails", result, {64'd16, 64'd0});
            run_op(2, 4'b0000,
                   {32'h10, 32'h50, 32'h10, 32'h10},
                   {32'h40, 32'h60, 32'h0, 32'h0},
                   {32'h20FFFFFF, 32'h40FFFFFF, 32'h00FFFFFF, 32'h00FFFFFF});
            chk("R2 word bounds and top-byte control", result, {64'd4, 64'd0});
        end

        exp_res = result; exp_cc = cc;
        for (int es = 0; es < 4; es++) begin
            for (int m = 0; m < 16; m++) begin
                for (int it = 0; it < 24; it++) begin
                    logic [127:0] a, b, c;
                    int ese = (es == 3) ? 0 : es;
                    a = rvec(ese, 1'b1);
                    b = rvec(ese, 1'b1);
                    c = {$urandom, $urandom, $urandom, $urandom};
                    run_op(es, 4'(m), a, b, c);
                    chk("R11 done sweep", 128'(done), 128'd1);
                    if (es == 3) begin
                        chk("R1 sweep flag", 128'({spec_err, cc_valid}), 128'({1'b1, 1'b0}));
                        chk("R1 sweep hold", {result, 126'd0, cc}, {exp_res, 126'd0, exp_cc});
                    end else begin
                        ref_model(es, 4'(m), a, b, c, r, ccx);
                        exp_res = r;
                        if (m[0]) exp_cc = ccx;
                        chk("R1 sweep flag clear", 128'(spec_err), 128'd0);
                        chk(m[2] ? "R6 sweep mask" : "R7 sweep index", result, r);
                        chk("R10 sweep cc_valid", 128'(cc_valid), 128'(m[0]));
                        chk(m[0] ? "R9 sweep cc" : "R10 sweep cc hold", 128'(cc), 128'(exp_cc));
                    end
                end
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule